// File: doc/BRIEF.md
# UART Transmit Framer with Line Control

This block serializes bytes into asynchronous frames on a single output line. Software writes a byte into a one-entry holding register. The framer moves that byte into a shifter at the next frame boundary and sends the frame. The framer is paced by a baud tick that pulses at sixteen times the bit rate. Each frame has these parts, in this order:

1. A low start bit.
2. Five to eight data bits, least significant first.
3. An optional parity bit.
4. A high stop interval of one, one and a half or two bit times.

An 8-bit line control register sets the frame format. It also holds a break control, which forces the line low without disturbing the sequencing. Its top bit is a bank select. When that bit is set, the two lowest register addresses reach a 16-bit divisor latch instead of the holding register and the interrupt-enable byte. A baud generator outside this block uses that divisor. The line idles high. A transmitter-empty flag tells software when both the holding register and the shifter are free.

Top module: `uartTxFramer`

## Requirements
- R1: After reset, `txd` is 1, `txEmpty` is 1, and a read of address 3 (line control) returns 0x00.
- R2: A frame starts with a 0 bit. Data bits follow, least significant first. Every bit lasts 16 baud ticks. Line control bits 1:0 give the data width: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8.
- R3: Line control bit 3 = 1 adds a parity bit after the data. When bit 4 = 1, the parity bit makes the count of ones in the data and parity even. When bit 4 = 0, it makes that count odd.
- R4: When bits 3 and 5 are both 1, the parity slot carries the inverse of bit 4, whatever the data.
- R5: When bit 3 = 0, bit 5 has no effect: no parity slot is sent and the frame length is unchanged.
- R6: When bit 2 = 0, the stop interval is 16 ticks. When bit 2 = 1, it is 24 ticks for a 5-bit word and 32 ticks for a 6 to 8 bit word.
- R7: While bit 6 = 1, `txd` is 0. Frame sequencing and the timing of `txEmpty` are unchanged.
- R8: When bit 7 = 1, writes to address 0 and address 1 set `divisor[7:0]` and `divisor[15:8]`, and reads of those addresses return them. When bit 7 = 0, address 0 writes the holding register and address 1 reads and writes an 8-bit interrupt-enable byte. Neither of these changes the divisor.
- R9: `txEmpty` is 1 only when the holding register is empty and no frame is in progress. A byte written during a frame is loaded on the tick that ends that frame, so the next start bit follows with no idle time between the frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 data/divisor low, 1 enable/divisor high, 3 line control) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr` (combinational) |
| baudTick | input | 1 | One-cycle pulse at 16x the bit rate |
| txd | output | 1 | Serial output |
| txEmpty | output | 1 | Holding register empty and shifter idle |
| divisor | output | 16 | Divisor latch value |

## Verification
The bench samples every bit slot at its centre and times each frame from its start edge to the rise of `txEmpty`. A bit counter or phase that is off by one shows up in two ways: a wrong level in a data or parity slot within 16 ticks, and a frame-length mismatch at the end of the stop interval. A wrong parity decision is visible in the one parity slot of the frame where it happens. A holding register that is loaded early or lost appears either as a missing second start edge or as `txEmpty` rising one frame too soon. A bank-select error corrupts the divisor, or the byte read back, on the cycle after the write.

// File: rtl/uartTxPkg.sv
package uartTxPkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_DATA  = 3'd2,
    PH_PAR   = 3'd3,
    PH_STOP  = 3'd4
  } txPhase_t;

  typedef struct packed {
    logic     load;
    logic     shift;
    txPhase_t phase;
  } txCtrl_t;

  typedef struct packed {
    logic       bankSel;
    logic       brk;
    logic       stickPar;
    logic       evenPar;
    logic       parEn;
    logic       stopSel;
    logic [1:0] wordLen;
  } lineCfg_t;
endpackage

// File: rtl/uartTxRegs.sv
module uartTxRegs
  import uartTxPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              loadAck,
  output logic [DATA_W-1:0] holdData,
  output logic              holdFull,
  output lineCfg_t          cfg,
  output logic [DIV_W-1:0]  divisor
);
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_ENAB = 2'd1;
  localparam logic [1:0] A_LINE = 2'd3;

  logic [DATA_W-1:0] lineQ;
  logic [DATA_W-1:0] enabQ;
  logic [DIV_W-1:0]  divQ;
  logic              bank;
  logic              wrHold;

  assign bank   = lineQ[7];
  assign wrHold = wrEn && (addr == A_DATA) && !bank;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineQ    <= '0;
      enabQ    <= '0;
      divQ     <= '0;
      holdData <= '0;
      holdFull <= 1'b0;
    end else begin
      if (wrEn) begin
        unique case (addr)
          A_DATA: if (bank) divQ[7:0] <= wrData[7:0];
          A_ENAB: if (bank) divQ[15:8] <= wrData[7:0];
                  else enabQ <= wrData;
          A_LINE: lineQ <= wrData;
          default: ;
        endcase
      end
      if (wrHold) begin
        holdData <= wrData;
        holdFull <= 1'b1;
      end else if (loadAck) begin
        holdFull <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (addr)
      A_DATA:  rdData = bank ? divQ[7:0] : '0;
      A_ENAB:  rdData = bank ? divQ[15:8] : enabQ;
      A_LINE:  rdData = lineQ;
      default: rdData = '0;
    endcase
  end

  assign cfg     = lineCfg_t'(lineQ[7:0]);
  assign divisor = divQ;
endmodule

// File: rtl/uartTxCtrl.sv
module uartTxCtrl
  import uartTxPkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     baudTick,
  input  logic     holdFull,
  input  lineCfg_t cfg,
  output txCtrl_t  ctrl
);
  localparam int CNT_W = $clog2(2 * TICKS_PER_BIT);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_ONE  = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] LAST_HALF = CNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_TWO  = CNT_W'(2 * TICKS_PER_BIT - 1);

  txPhase_t          phaseQ, phaseD;
  logic [CNT_W-1:0]  tickCnt, tickCntD;
  logic [IDX_W-1:0]  bitIdx, bitIdxD;
  logic [CNT_W-1:0]  lastTick;
  logic [IDX_W-1:0]  lastBit;
  logic              tickEnd;
  logic              loadNow;
  logic              shiftNow;

  always_comb begin
    if (phaseQ == PH_STOP && cfg.stopSel)
      lastTick = (cfg.wordLen == 2'b00) ? LAST_HALF : LAST_TWO;
    else
      lastTick = LAST_ONE;
  end

  assign lastBit = IDX_W'(4) + IDX_W'(cfg.wordLen);
  assign tickEnd = baudTick && (tickCnt == lastTick);

  always_comb begin
    phaseD   = phaseQ;
    tickCntD = tickCnt;
    bitIdxD  = bitIdx;
    loadNow  = 1'b0;
    shiftNow = 1'b0;
    if (baudTick && phaseQ != PH_IDLE)
      tickCntD = tickEnd ? '0 : tickCnt + 1'b1;
    unique case (phaseQ)
      PH_IDLE: begin
        if (baudTick && holdFull) begin
          loadNow  = 1'b1;
          phaseD   = PH_START;
          tickCntD = '0;
        end
      end
      PH_START: begin
        if (tickEnd) begin
          phaseD  = PH_DATA;
          bitIdxD = '0;
        end
      end
      PH_DATA: begin
        if (tickEnd) begin
          shiftNow = 1'b1;
          if (bitIdx == lastBit)
            phaseD = cfg.parEn ? PH_PAR : PH_STOP;
          else
            bitIdxD = bitIdx + 1'b1;
        end
      end
      PH_PAR: begin
        if (tickEnd) phaseD = PH_STOP;
      end
      PH_STOP: begin
        if (tickEnd) begin
          if (holdFull) begin
            loadNow = 1'b1;
            phaseD  = PH_START;
          end else begin
            phaseD = PH_IDLE;
          end
        end
      end
      default: phaseD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ  <= PH_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      phaseQ  <= phaseD;
      tickCnt <= tickCntD;
      bitIdx  <= bitIdxD;
    end
  end

  assign ctrl.load  = loadNow;
  assign ctrl.shift = shiftNow;
  assign ctrl.phase = phaseQ;
endmodule

// File: rtl/uartTxDatapath.sv
module uartTxDatapath
  import uartTxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txCtrl_t           ctrl,
  input  lineCfg_t          cfg,
  input  logic [DATA_W-1:0] holdData,
  output logic              txd
);
  logic [DATA_W-1:0] shiftQ;
  logic              parQ;
  logic [DATA_W-1:0] mask;
  logic              dataXor;
  logic              parNext;

  assign mask    = {DATA_W{1'b1}} >> (2'd3 - cfg.wordLen);
  assign dataXor = ^(holdData & mask);

  always_comb begin
    if (cfg.stickPar) parNext = ~cfg.evenPar;
    else              parNext = cfg.evenPar ? dataXor : ~dataXor;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      parQ   <= 1'b0;
    end else if (ctrl.load) begin
      shiftQ <= holdData;
      parQ   <= parNext;
    end else if (ctrl.shift) begin
      shiftQ <= shiftQ >> 1;
    end
  end

  logic lineLevel;
  always_comb begin
    unique case (ctrl.phase)
      PH_START: lineLevel = 1'b0;
      PH_DATA:  lineLevel = shiftQ[0];
      PH_PAR:   lineLevel = parQ;
      default:  lineLevel = 1'b1;
    endcase
  end

  assign txd = cfg.brk ? 1'b0 : lineLevel;
endmodule

// File: rtl/uartTxFramer.sv
module uartTxFramer
  import uartTxPkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8,
  parameter int DIV_W         = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              baudTick,
  output logic              txd,
  output logic              txEmpty,
  output logic [DIV_W-1:0]  divisor
);
  txCtrl_t           ctrl;
  lineCfg_t          cfg;
  logic [DATA_W-1:0] holdData;
  logic              holdFull;
  logic [7:0]        lineQ;

  assign lineQ = cfg;

  uartTxRegs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .loadAck(ctrl.load), .holdData(holdData),
    .holdFull(holdFull), .cfg(cfg), .divisor(divisor)
  );

  uartTxCtrl #(.TICKS_PER_BIT(TICKS_PER_BIT), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .holdFull(holdFull),
    .cfg(cfg), .ctrl(ctrl)
  );

  uartTxDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .cfg(cfg), .holdData(holdData),
    .txd(txd)
  );

  assign txEmpty = !holdFull && (ctrl.phase == PH_IDLE);
endmodule

// File: rtl/uartTxFramerChk.sv
module uartTxFramerChk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [1:0]  addr,
  input logic [7:0]  wrData,
  input logic [7:0]  lineQ,
  input logic        txd,
  input logic        txEmpty,
  input logic [15:0] divisor
);
  assert_break_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    lineQ[6] |-> !txd);

  assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rstN)
    (txEmpty && !lineQ[6]) |-> txd);

  assert_write_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd0 && !lineQ[7]) |=> !txEmpty);

  assert_div_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd0 && lineQ[7]) |=> divisor[7:0] == $past(wrData));

  assert_div_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd1 && lineQ[7]) |=> divisor[15:8] == $past(wrData));

  assert_div_kept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr != 2'd3 && !lineQ[7]) |=> $stable(divisor));
endmodule

bind uartTxFramer uartTxFramerChk i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .lineQ(lineQ), .txd(txd), .txEmpty(txEmpty), .divisor(divisor)
);

// File: tb/test_uartTxFramer.sv
module test_uartTxFramer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  wrData = 8'd0;
  logic [7:0]  rdData;
  logic        baudTick = 1'b1;
  logic        txd;
  logic        txEmpty;
  logic [15:0] divisor;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #2.5 clk = ~clk;

  uartTxFramer i_uartTxFramer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .baudTick(baudTick), .txd(txd), .txEmpty(txEmpty),
    .divisor(divisor)
  );

  // {line control, data byte, expected ticks from start edge to empty}
  localparam logic [23:0] VEC [10] = '{
    {8'h03, 8'hA5, 8'd160},  // R2 8 data, 1 stop
    {8'h00, 8'h1F, 8'd112},  // R2 5 data
    {8'h04, 8'h16, 8'd120},  // R6 5 data, 1.5 stop
    {8'h07, 8'h3C, 8'd176},  // R6 8 data, 2 stop
    {8'h1B, 8'h07, 8'd176},  // R3 even parity
    {8'h0A, 8'h55, 8'd160},  // R3 odd parity, 7 data
    {8'h3B, 8'hFF, 8'd176},  // R4 sticky, even select -> 0
    {8'h2B, 8'h00, 8'd176},  // R4 sticky, odd select -> 1
    {8'h21, 8'h2A, 8'd128},  // R5 sticky ignored, 6 data
    {8'h0E, 8'h80, 8'd176}   // R6 7 data, 2 stop, odd parity
  };

  task automatic check(input string req, input int actual, input int expected,
                       input string what);
    nChecks++;
    if (actual != expected) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic expSlot(input logic [7:0] lc, input logic [7:0] d,
                                   input int s);
    int n = 5 + int'(lc[1:0]);
    logic x = 1'b0;
    if (s == 0) return 1'b0;
    if (s <= n) return d[s-1];
    for (int k = 0; k < n; k++) x ^= d[k];
    if (lc[5]) return ~lc[4];
    return lc[4] ? x : ~x;
  endfunction

  task automatic runFrame(input logic [7:0] lc, input logic [7:0] d,
                          input int ticks, input string req);
    int pos = 0;
    int guard = 0;
    int n = 5 + int'(lc[1:0]);
    int slots = 1 + n + (lc[3] ? 1 : 0);
    regWrite(2'd3, lc);
    regWrite(2'd0, d);
    while (txd !== 1'b0 && guard < 100) begin
      @(negedge clk); guard++;
    end
    for (int s = 0; s < slots; s++) begin
      int target = 16 * s + 8;
      repeat (target - pos) @(negedge clk);
      pos = target;
      check(req, int'(txd), int'(expSlot(lc, d, s)), $sformatf("slot %0d lc %h", s, lc));
    end
    while (!txEmpty && pos < 400) begin
      @(negedge clk); pos++;
    end
    check(req, pos, ticks, $sformatf("frame ticks lc %h", lc));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    addr = 2'd3;
    #0.1;
    check("R1", int'(txd), 1, "txd after reset");
    check("R1", int'(txEmpty), 1, "txEmpty after reset");
    check("R1", int'(rdData), 0, "line control after reset");

    for (int i = 0; i < 10; i++)
      runFrame(VEC[i][23:16], VEC[i][15:8], int'(VEC[i][7:0]), "R2/R3/R4/R5/R6");

    // R8 banked divisor access
    regWrite(2'd3, 8'h83);
    regWrite(2'd0, 8'h34);
    regWrite(2'd1, 8'h12);
    check("R8", int'(divisor), 16'h1234, "divisor after bank writes");
    check("R8", int'(txEmpty), 1, "no frame from bank write");
    addr = 2'd0; #0.1;
    check("R8", int'(rdData), 8'h34, "read divisor low");
    regWrite(2'd3, 8'h03);
    regWrite(2'd1, 8'h05);
    addr = 2'd1; #0.1;
    check("R8", int'(rdData), 8'h05, "read enable byte");
    check("R8", int'(divisor), 16'h1234, "divisor unchanged by enable write");

    // R7 break: line low, timing unchanged
    begin
      int k = 0;
      int hiSeen = 0;
      regWrite(2'd3, 8'h43);
      regWrite(2'd0, 8'hFF);
      while (!txEmpty && k < 400) begin
        @(negedge clk); k++;
        if (txd) hiSeen++;
      end
      check("R7", hiSeen, 0, "txd high during break");
      check("R7", k, 161, "empty timing under break");
      check("R7", int'(txd), 0, "txd held low while idle");
      regWrite(2'd3, 8'h03);
      check("R7", int'(txd), 1, "txd back to mark");
    end

    // R9 back-to-back frames
    begin
      int k = 0;
      int emptySeen = 0;
      regWrite(2'd0, 8'h00);
      regWrite(2'd0, 8'hFF);
      while (!txEmpty && k < 600) begin
        @(negedge clk); k++;
        if (k == 158) check("R9", int'(txd), 1, "stop of first frame");
        if (k == 159) check("R9", int'(txd), 0, "second start directly after");
        if (txEmpty && k < 319) emptySeen++;
      end
      check("R9", emptySeen, 0, "empty flag during queued frame");
      check("R9", k, 319, "two-frame length");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule